// File: doc/BRIEF.md
# Registered Read-Only Memory with Initialize Word

This block is a read-only word store whose read path ends in an edge-triggered output register. The address applied before a rising clock edge selects a word, and that word appears on the data outputs just after the edge. It then stays put whatever the address does until the next edge. Downstream logic can therefore treat the block like a pipelined microprogram store: the next address is set up while the current word is still held.

Two extra stored values shape the output. An initialize word is forced into the output register whenever the active-low initialize input is low. This is a level, it needs no clock, and it can act as a clear, a preset or a fixed start value. A control bit selects how the output enable behaves. It is either a plain combinational gate, or a flag sampled on the rising edge so that the outputs switch on and off in step with the data. The outputs never float: a drive flag stands for the pad drivers, and the data bus reads zero whenever that flag is low.

The array, the initialize word and the control bit are filled through a simple load port before use. That port acts only while a program-mode input is high. A synchronous active-low reset models power-up: it clears the register, the initialize word and the control bit, and leaves the array contents alone.

Top module: `regrom_top`

## Requirements
- R1: When `init_n` is high, each rising edge captures the array word at `addr` into the output register, and that word is on `dout` from that edge onward. Changes of `addr` between edges leave `dout` unchanged.
- R2: With `prog_en` and `load_en` both high at a rising edge, `load_data` is written to array location `load_addr` when bit ADDR_W of `load_addr` is 0. It goes to the initialize word when `load_addr` equals 2^ADDR_W, and bit 0 of it goes to the enable-mode control bit when `load_addr` equals 2^ADDR_W+1.
- R3: `load_en` with `prog_en` low changes no stored value, either in the array or in the initialize word.
- R4: A low level on `init_n` puts the initialize word into the output register at once, with no clock edge, and keeps it there while `init_n` stays low.
- R5: If `init_n` rises between clock edges, the register keeps the initialize word until the next rising edge, and that edge captures array data again.
- R6: An initialize word never loaded since reset is all zeros, so initialize clears the outputs. After 8'hFF is loaded it presets them to all ones.
- R7: With the control bit 0 (asynchronous mode, the reset default), `drive` equals the inverse of `oe_n` at all times and follows it without a clock.
- R8: With the control bit 1 (synchronous mode), `oe_n` is sampled at each rising edge. `drive` is high from an edge that sampled `oe_n` low and low from an edge that sampled it high, and it does not move between edges.
- R9: Whenever `drive` is low, `dout` is all zeros.
- R10: A rising edge with `rst_n` low clears the output register, the initialize word and the control bit, and marks the sampled enable as off. Array contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up model) |
| init_n | input | 1 | Level-sensitive active-low initialize |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Read address |
| prog_en | input | 1 | Program mode; allows the load port to write |
| load_en | input | 1 | Load strobe |
| load_addr | input | ADDR_W+1 | Load location: array, initialize word or control |
| load_data | input | DATA_W | Load value |
| dout | output | DATA_W | Registered data, zero while not driven |
| drive | output | 1 | High when the outputs would be driven |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 8. With that size, a 64-word array can be filled completely and read back in every location. The initialize slot (64) and control slot (65) then sit only a few loads away, and thousands of random cycles revisit each address and both enable modes many times. A bench model predicts the output register, the sampled enable, and every initialize pulse placed between clock edges.

// File: rtl/regrom_pkg.sv
// Shared types for the registered ROM.
package regrom_pkg;
    // Output enable behaviour chosen by the stored control bit.
    typedef enum logic {
        OE_ASYNC = 1'b0,
        OE_SYNC  = 1'b1
    } oe_mode_e;
endpackage

// File: rtl/regrom_store.sv
// Word store: data array, initialize word and control bit.
// Assumes writes arrive only when the caller has qualified them with program
// mode. The array is not reset; the two extra locations clear on rst_n.
module regrom_store
    import regrom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] init_word,
    output oe_mode_e          mode
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] INIT_SLOT = (ADDR_W+1)'(DEPTH);
    localparam logic [ADDR_W:0] CTRL_SLOT = (ADDR_W+1)'(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] init_q;
    logic              ctrl_q;

    // Array write: only locations below DEPTH.
    always_ff @(posedge clk) begin
        if (wr_en && !wr_addr[ADDR_W]) begin
            mem[wr_addr[ADDR_W-1:0]] <= wr_data;
        end
    end

    // Extra locations: initialize word and enable-mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            ctrl_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == INIT_SLOT) init_q <= wr_data;
            if (wr_addr == CTRL_SLOT) ctrl_q <= wr_data[0];
        end
    end

    // Read path feeding the output register.
    always_comb begin
        rd_data   = mem[rd_addr];
        init_word = init_q;
        mode      = oe_mode_e'(ctrl_q);
    end
endmodule

// File: rtl/regrom_outreg.sv
// Output register with level-sensitive asynchronous load of the init word.
// Assumes init_word is stable while init_n is low.
module regrom_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic [DATA_W-1:0] init_word,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] q
);
    // Init level wins over everything; otherwise capture read data on the edge.
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) begin
            q <= init_word;
        end else if (!rst_n) begin
            q <= '0;
        end else begin
            q <= rd_data;
        end
    end
endmodule

// File: rtl/regrom_oe.sv
// Output enable: combinational gate or edge-sampled flag, chosen by mode.
// Assumes oe_n meets setup to clk when the sampled form is selected.
module regrom_oe
    import regrom_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     oe_n,
    input  oe_mode_e mode,
    output logic     drive
);
    logic off_q;

    // Sampled enable; reset leaves it in the off (set) condition.
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= 1'b1;
        else        off_q <= oe_n;
    end

    // Select the enable form.
    always_comb begin
        drive = (mode == OE_SYNC) ? !off_q : !oe_n;
    end
endmodule

// File: rtl/regrom_top.sv
// Registered ROM top: store, output register and enable logic.
// Assumes the load port is used only with prog_en high; reads keep working
// during program mode.
module regrom_top
    import regrom_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              prog_en,
    input  logic              load_en,
    input  logic [ADDR_W:0]   load_addr,
    input  logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] init_word;
    logic [DATA_W-1:0] reg_q;
    oe_mode_e          mode;
    logic              sync_sel;
    logic              wr_en;

    // Load port is qualified by program mode.
    always_comb begin
        wr_en    = prog_en && load_en;
        sync_sel = (mode == OE_SYNC);
    end

    regrom_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(load_addr),
        .wr_data(load_data), .rd_addr(addr), .rd_data(rd_data),
        .init_word(init_word), .mode(mode)
    );

    regrom_outreg #(.DATA_W(DATA_W)) outreg_i (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .init_word(init_word),
        .rd_data(rd_data), .q(reg_q)
    );

    regrom_oe oe_i (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .mode(mode), .drive(drive)
    );

    // Undriven outputs read as zero.
    always_comb begin
        dout = drive ? reg_q : '0;
    end
endmodule

// File: rtl/regrom_chk.sv
// Property checker for regrom_top, attached by bind below.
module regrom_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_n,
    input logic              oe_n,
    input logic              drive,
    input logic [DATA_W-1:0] dout,
    input logic [DATA_W-1:0] reg_q,
    input logic [DATA_W-1:0] init_word,
    input logic [DATA_W-1:0] rd_data,
    input logic              sync_sel
);
    logic init_hit;

    // Notes any initialize activity since the previous clock edge.
    always_ff @(posedge clk or negedge init_n) begin
        if (!init_n) init_hit <= 1'b1;
        else         init_hit <= 1'b0;
    end

    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !init_hit) |-> (reg_q === $past(rd_data)));

    assert_init_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n |-> (reg_q === init_word));

    assert_async_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_sel |-> (drive == !oe_n));

    assert_sync_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sync_sel) |-> (drive == !$past(oe_n)));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !drive |-> (dout === '0));

    logic [ADDR_W-1:0] unused_w;
    always_comb unused_w = '0;
endmodule

bind regrom_top regrom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .oe_n(oe_n), .drive(drive),
    .dout(dout), .reg_q(reg_q), .init_word(init_word), .rd_data(rd_data),
    .sync_sel(sync_sel)
);

// File: tb/regrom_top_tb_top.sv
`timescale 1ns/100ps
module regrom_top_tb_top;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init_n = 1'b1;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          prog_en = 1'b0;
    logic          load_en = 1'b0;
    logic [AW:0]   load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic [DW-1:0] dout;
    logic          drive;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Reference state
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] m_q = '0;
    logic [DW-1:0] m_iw = '0;
    logic          m_ctl = 1'b0;
    logic          m_off = 1'b1;

    always #2 clk = ~clk;

    regrom_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_n(init_n), .oe_n(oe_n), .addr(addr),
        .prog_en(prog_en), .load_en(load_en), .load_addr(load_addr),
        .load_data(load_data), .dout(dout), .drive(drive)
    );

    function automatic logic exp_drive();
        return m_ctl ? !m_off : !oe_n;
    endfunction

    function automatic logic [DW-1:0] exp_dout();
        return exp_drive() ? m_q : '0;
    endfunction

    task automatic chk(string tag);
        total++;
        if (dout !== exp_dout() || drive !== exp_drive()) begin
            bad++;
            $display("FAIL %s: dout=%h drive=%b expected dout=%h drive=%b",
                     tag, dout, drive, exp_dout(), exp_drive());
        end
    endtask

    // One rising edge; model update mirrors the requirements, then check.
    task automatic step(string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_q = init_n ? '0 : m_iw;
            m_off = 1'b1; m_iw = '0; m_ctl = 1'b0;
        end else begin
            m_q = init_n ? m_mem[addr] : m_iw;
            m_off = oe_n;
            if (prog_en && load_en) begin
                if (!load_addr[AW]) m_mem[load_addr[AW-1:0]] = load_data;
                else if (load_addr == 7'(DEPTH)) m_iw = load_data;
                else if (load_addr == 7'(DEPTH + 1)) m_ctl = load_data[0];
            end
        end
        #1;
        chk(tag);
    endtask

    task automatic load(input logic [AW:0] a, input logic [DW-1:0] d);
        prog_en = 1'b1; load_en = 1'b1; load_addr = a; load_data = d;
        step("R2");
        prog_en = 1'b0; load_en = 1'b0;
    endtask

    // Init pulse placed between clock edges.
    task automatic pulse_init(string tag);
        init_n = 1'b0;
        #0.5;
        m_q = m_iw;
        chk(tag);
        init_n = 1'b1;
        #0.5;
        chk("R5");
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step("R10");
        rst_n = 1'b1;
        step("R10");

        // Fill and read back every location (R2, R1)
        for (int i = 0; i < DEPTH; i++) load(7'(i), 8'($urandom));
        for (int i = 0; i < DEPTH; i++) begin
            addr = 6'(i);
            step("R1");
            addr = 6'(i + 17);
            #0.5;
            chk("R1");
        end

        // Ignored load without program mode (R3)
        addr = 6'd5;
        load_en = 1'b1; load_addr = 7'd5; load_data = ~m_mem[5];
        step("R3");
        load_addr = 7'(DEPTH); load_data = 8'h3C;
        step("R3");
        load_en = 1'b0;
        step("R3");
        pulse_init("R3");

        // Blank init word clears, all ones presets (R6)
        pulse_init("R6");
        step("R5");
        load(7'(DEPTH), 8'hFF);
        pulse_init("R6");
        step("R5");
        load(7'(DEPTH), 8'hA5);

        // Held init across edges (R4)
        init_n = 1'b0;
        #0.5; m_q = m_iw; chk("R4");
        addr = 6'd9;
        step("R4");
        step("R4");
        oe_n = 1'b1; #0.5; chk("R7");
        oe_n = 1'b0; #0.5; chk("R4");
        init_n = 1'b1; #0.5; chk("R5");
        step("R5");

        // Asynchronous enable (R7, R9)
        oe_n = 1'b1; #0.5; chk("R7");
        step("R9");
        oe_n = 1'b0; #0.5; chk("R7");

        // Synchronous enable (R8, R9)
        load(7'(DEPTH + 1), 8'h01);
        oe_n = 1'b1; #0.5; chk("R8");
        step("R8");
        step("R9");
        oe_n = 1'b0; #0.5; chk("R8");
        step("R8");

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            addr = 6'($urandom);
            oe_n = ($urandom % 4) == 0;
            #0.3;
            chk(m_ctl ? "R8" : "R7");
            if ($urandom % 40 == 0) pulse_init("R4");
            if (i % 1000 == 500) load(7'(DEPTH + 1), {7'($urandom), ~m_ctl});
            else step("R1");
        end

        // Reset keeps array, clears init word and mode (R10)
        oe_n = 1'b0;
        rst_n = 1'b0;
        step("R10");
        rst_n = 1'b1;
        addr = 6'd33;
        step("R10");
        pulse_init("R10");
        step("R10");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule